// File: doc/BRIEF.md
# Register-Pair Address Generator with Reverse-Carry Stepping

This block produces the addresses for one port of a shared data memory. It holds a parameterized set of register pairs, 16 by default. Each pair has a step register, a working address register and a 2-bit update mode. Software programs a pair once with its step value, starting address and mode. After that, every access that names the pair does two things: it presents the current address on the output, and it advances the working register by the rule the mode selects.

Four update rules are available. The step can be added, subtracted, or reloaded as the new address. The fourth rule adds the step with its carry running from the most significant bit down toward the least significant bit. With a step equal to the top bit's weight, this reverse-carry addition walks through the bit-reversed ordering that FFT reordering needs, cyclically. All arithmetic wraps modulo 2^AW.

Top module: `sau_top`

## Requirements
- R1: On reset every working address register becomes 0 and every pair is put in mode 00 (add). Pair 0 receives a step of 1 and every other pair a step of 0. Repeated accesses to pair 0 therefore yield 0, 1, 2, …
- R2: A configuration write (cfgWe high, pair chosen by cfgIdx) stores cfgBase as the step, cfgMode as the mode and cfgStart as the working address. The next access to that pair outputs cfgStart.
- R3: addrOut always shows the working address of the pair selected by accIdx. During an access this is the value before that access's update.
- R4: Mode 00: each access replaces the address with address + step, modulo 2^AW.
- R5: Mode 01: each access replaces the address with address − step, modulo 2^AW.
- R6: Mode 10: each access adds the step with the carry moving from bit AW−1 toward bit 0. Starting at 0 with a step of 2^(AW−1), the k-th output is k with its AW bits reversed: 0x0000, 0x8000, 0x4000, 0xC000, 0x2000, … for AW=16. All ones is followed by 0.
- R7: Mode 11: each access loads the step value into the address register.
- R8: Only the pair named by an access is updated. The other pairs, and every pair in a cycle with no access and no configuration write, keep their values.
- R9: When a configuration write and an access name the same pair in the same cycle, the configuration write wins and no update is applied.
- R10: A configuration write to one pair and an access to a different pair in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | IW | Pair to configure |
| cfgMode | input | 2 | Update mode: 00 add, 01 subtract, 10 reverse-carry add, 11 reload |
| cfgBase | input | AW | Step value for the pair |
| cfgStart | input | AW | Starting working address |
| accEn | input | 1 | Memory access strobe |
| accIdx | input | IW | Pair used by the access, also selects addrOut |
| addrOut | output | AW | Current working address of the selected pair |

## Verification
The assertions assume that accIdx and cfgIdx always name an existing pair. They also assume that a step can only be seen on addrOut when accIdx is held at the same pair in the following cycle. Every stepping check relaxes to true whenever accIdx moves. The directed scenarios keep both indices inside the pair count. They hold accIdx on one pair through each run of accesses and read back results in a cycle with no access. The checker's own shadow of steps and modes therefore follows the configuration writes exactly.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [1:0] {
    MODE_INC    = 2'b00,
    MODE_DEC    = 2'b01,
    MODE_REV    = 2'b10,
    MODE_RELOAD = 2'b11
  } mode_e;

  // per-pair strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;

endpackage

// File: rtl/sau_ctrl.sv
module sau_ctrl #(
  parameter int PAIRS = 16,
  localparam int IW = $clog2(PAIRS)
) (
  input  logic                          cfgWe,
  input  logic [IW-1:0]                 cfgIdx,
  input  logic                          accEn,
  input  logic [IW-1:0]                 accIdx,
  output sau_pkg::strobe_t [PAIRS-1:0]  strb
);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic cfgHit;
    logic accHit;
    assign cfgHit       = cfgWe && (cfgIdx == IW'(p));
    assign accHit       = accEn && (accIdx == IW'(p));
    // a configuration write to the same pair overrides the step
    assign strb[p].load = cfgHit;
    assign strb[p].step = accHit && !cfgHit;
  end

endmodule

// File: rtl/sau_step_unit.sv
module sau_step_unit #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]   curAddr,
  input  logic [AW-1:0]   stepVal,
  input  sau_pkg::mode_e  mode,
  output logic [AW-1:0]   nxtAddr
);

  logic [AW-1:0] revAddr;
  logic [AW-1:0] revStep;
  logic [AW-1:0] revSum;
  logic [AW-1:0] rcSum;

  // mirrored operands turn a normal adder into a top-down carry chain
  for (genvar b = 0; b < AW; b++) begin : g_mirror
    assign revAddr[b] = curAddr[AW-1-b];
    assign revStep[b] = stepVal[AW-1-b];
    assign rcSum[b]   = revSum[AW-1-b];
  end

  assign revSum = revAddr + revStep;

  always_comb begin
    unique case (mode)
      sau_pkg::MODE_INC:    nxtAddr = curAddr + stepVal;
      sau_pkg::MODE_DEC:    nxtAddr = curAddr - stepVal;
      sau_pkg::MODE_REV:    nxtAddr = rcSum;
      sau_pkg::MODE_RELOAD: nxtAddr = stepVal;
      default:              nxtAddr = curAddr;
    endcase
  end

endmodule

// File: rtl/sau_datapath.sv
module sau_datapath #(
  parameter int PAIRS = 16,
  parameter int AW    = 16,
  localparam int IW = $clog2(PAIRS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sau_pkg::strobe_t [PAIRS-1:0]  strb,
  input  logic [1:0]                    cfgMode,
  input  logic [AW-1:0]                 cfgBase,
  input  logic [AW-1:0]                 cfgStart,
  input  logic [IW-1:0]                 accIdx,
  output logic [AW-1:0]                 addrOut
);

  logic [AW-1:0]   addrQ [PAIRS];
  logic [AW-1:0]   baseQ [PAIRS];
  sau_pkg::mode_e  modeQ [PAIRS];
  logic [AW-1:0]   nxtAddr [PAIRS];

  for (genvar p = 0; p < PAIRS; p++) begin : g_step
    sau_step_unit #(.AW(AW)) u_step (
      .curAddr (addrQ[p]),
      .stepVal (baseQ[p]),
      .mode    (modeQ[p]),
      .nxtAddr (nxtAddr[p])
    );
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PAIRS; p++) begin
      if (!rstN) begin
        addrQ[p] <= '0;
        baseQ[p] <= (p == 0) ? AW'(1) : '0;
        modeQ[p] <= sau_pkg::MODE_INC;
      end else if (strb[p].load) begin
        addrQ[p] <= cfgStart;
        baseQ[p] <= cfgBase;
        modeQ[p] <= sau_pkg::mode_e'(cfgMode);
      end else if (strb[p].step) begin
        addrQ[p] <= nxtAddr[p];
      end
    end
  end

  // pre-update address of the selected pair
  assign addrOut = addrQ[accIdx];

endmodule

// File: rtl/sau_top.sv
module sau_top #(
  parameter int PAIRS = 16,
  parameter int AW    = 16,
  localparam int IW = $clog2(PAIRS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [IW-1:0]  cfgIdx,
  input  logic [1:0]     cfgMode,
  input  logic [AW-1:0]  cfgBase,
  input  logic [AW-1:0]  cfgStart,
  input  logic           accEn,
  input  logic [IW-1:0]  accIdx,
  output logic [AW-1:0]  addrOut
);

  sau_pkg::strobe_t [PAIRS-1:0] strb;

  sau_ctrl #(.PAIRS(PAIRS)) u_ctrl (
    .cfgWe  (cfgWe),
    .cfgIdx (cfgIdx),
    .accEn  (accEn),
    .accIdx (accIdx),
    .strb   (strb)
  );

  sau_datapath #(.PAIRS(PAIRS), .AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgMode  (cfgMode),
    .cfgBase  (cfgBase),
    .cfgStart (cfgStart),
    .accIdx   (accIdx),
    .addrOut  (addrOut)
  );

endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
  parameter int PAIRS = 16,
  parameter int AW    = 16,
  localparam int IW = $clog2(PAIRS)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgWe,
  input logic [IW-1:0]                 cfgIdx,
  input logic [1:0]                    cfgMode,
  input logic [AW-1:0]                 cfgBase,
  input logic [AW-1:0]                 cfgStart,
  input logic                          accEn,
  input logic [IW-1:0]                 accIdx,
  input logic [AW-1:0]                 addrOut,
  input sau_pkg::strobe_t [PAIRS-1:0]  strb
);

  logic [AW-1:0] shBase [PAIRS];
  logic [1:0]    shMode [PAIRS];
  logic [AW-1:0] curBase;
  logic [1:0]    curMode;
  logic [AW-1:0] expNext;
  logic [PAIRS-1:0] stepBits;
  logic [PAIRS-1:0] loadBits;
  logic          stepGo;

  function automatic logic [AW-1:0] rippleDown(input logic [AW-1:0] a,
                                               input logic [AW-1:0] b);
    logic c;
    logic [AW-1:0] s;
    c = 1'b0;
    for (int i = AW - 1; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PAIRS; p++) begin
        shBase[p] <= (p == 0) ? AW'(1) : '0;
        shMode[p] <= 2'b00;
      end
    end else if (cfgWe) begin
      shBase[cfgIdx] <= cfgBase;
      shMode[cfgIdx] <= cfgMode;
    end
  end

  always_comb begin
    curBase = shBase[accIdx];
    curMode = shMode[accIdx];
    case (curMode)
      2'b00:   expNext = addrOut + curBase;
      2'b01:   expNext = addrOut - curBase;
      2'b10:   expNext = rippleDown(addrOut, curBase);
      default: expNext = curBase;
    endcase
    for (int p = 0; p < PAIRS; p++) begin
      stepBits[p] = strb[p].step;
      loadBits[p] = strb[p].load;
    end
  end

  assign stepGo = accEn && !(cfgWe && (cfgIdx == accIdx));

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && !accEn) |=> ((accIdx != $past(accIdx)) || $stable(addrOut))); // R8

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> ((accIdx != $past(cfgIdx)) || (addrOut == $past(cfgStart)))); // R2

  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && accEn && (cfgIdx == accIdx)) |=>
      ((accIdx != $past(accIdx)) || (addrOut == $past(cfgStart)))); // R9

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rstN)
    (stepGo && curMode == 2'b00) |=>
      ((accIdx != $past(accIdx)) || (addrOut == $past(expNext)))); // R4

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (stepGo && curMode == 2'b01) |=>
      ((accIdx != $past(accIdx)) || (addrOut == $past(expNext)))); // R5

  AST_STEP_REV: assert property (@(posedge clk) disable iff (!rstN)
    (stepGo && curMode == 2'b10) |=>
      ((accIdx != $past(accIdx)) || (addrOut == $past(expNext)))); // R6

  AST_STEP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stepGo && curMode == 2'b11) |=>
      ((accIdx != $past(accIdx)) || (addrOut == $past(expNext)))); // R7

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stepBits)); // R8

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadBits)); // R2

endmodule

bind sau_top sau_checker #(.PAIRS(PAIRS), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgIdx   (cfgIdx),
  .cfgMode  (cfgMode),
  .cfgBase  (cfgBase),
  .cfgStart (cfgStart),
  .accEn    (accEn),
  .accIdx   (accIdx),
  .addrOut  (addrOut),
  .strb     (strb)
);

// File: tb/tb_sau_top.sv
`timescale 1ns/1ps
module tb_sau_top;

  localparam int PAIRS = 16;
  localparam int AW    = 16;
  localparam int IW    = $clog2(PAIRS);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cfgWe = 1'b0;
  logic [IW-1:0]  cfgIdx = '0;
  logic [1:0]     cfgMode = '0;
  logic [AW-1:0]  cfgBase = '0;
  logic [AW-1:0]  cfgStart = '0;
  logic           accEn = 1'b0;
  logic [IW-1:0]  accIdx = '0;
  logic [AW-1:0]  addrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sau_top #(.PAIRS(PAIRS), .AW(AW)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgMode(cfgMode),
    .cfgBase(cfgBase), .cfgStart(cfgStart), .accEn(accEn), .accIdx(accIdx),
    .addrOut(addrOut)
  );

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  function automatic logic [AW-1:0] rcModel(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return flip(flip(a) + flip(b));
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWe = 1'b0; accEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cfg(input int idx, input logic [1:0] md, input logic [AW-1:0] st,
                     input logic [AW-1:0] start);
    @(negedge clk);
    accEn = 1'b0; cfgWe = 1'b1; cfgIdx = IW'(idx);
    cfgMode = md; cfgBase = st; cfgStart = start;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one access: output checked before the edge applies the update
  task automatic stepChk(input string tag, input int idx, input logic [AW-1:0] exp);
    @(negedge clk);
    cfgWe = 1'b0; accEn = 1'b1; accIdx = IW'(idx);
    #1 chk(tag, addrOut, exp);
  endtask

  task automatic peek(input string tag, input int idx, input logic [AW-1:0] exp);
    @(negedge clk);
    accEn = 1'b0; cfgWe = 1'b0; accIdx = IW'(idx);
    #1 chk(tag, addrOut, exp);
  endtask

  task automatic testReset();
    peek("R1 pair0 after reset", 0, 16'h0000);
    peek("R1 pair7 after reset", 7, 16'h0000);
    for (int k = 0; k < 4; k++) stepChk("R1 pair0 counts by one", 0, AW'(k));
    peek("R1 pair0 after four accesses", 0, 16'h0004);
    stepChk("R1 pair7 zero step", 7, 16'h0000);
    stepChk("R1 pair7 zero step again", 7, 16'h0000);
    peek("R3 pair7 held", 7, 16'h0000);
  endtask

  task automatic testInc();
    cfg(3, 2'b00, 16'd5, 16'd10);
    stepChk("R2 first access gives start", 3, 16'd10);
    stepChk("R4 add step", 3, 16'd15);
    stepChk("R4 add step again", 3, 16'd20);
    peek("R4 after adds", 3, 16'd25);
    cfg(3, 2'b00, 16'h0010, 16'hFFF8);
    stepChk("R4 before wrap", 3, 16'hFFF8);
    peek("R4 wraps modulo", 3, 16'h0008);
  endtask

  task automatic testDec();
    cfg(4, 2'b01, 16'd2, 16'd3);
    stepChk("R5 start", 4, 16'd3);
    stepChk("R5 subtract", 4, 16'd1);
    stepChk("R5 borrow wraps", 4, 16'hFFFF);
    peek("R5 after subtracts", 4, 16'hFFFD);
  endtask

  task automatic testRev();
    logic [AW-1:0] model;
    cfg(6, 2'b10, 16'h8000, 16'h0000);
    for (int k = 0; k < 16; k++) stepChk("R6 bit-reversed count", 6, flip(AW'(k)));
    cfg(6, 2'b10, 16'h8000, 16'hFFFF);
    stepChk("R6 all ones", 6, 16'hFFFF);
    peek("R6 all ones wraps to zero", 6, 16'h0000);
    cfg(6, 2'b10, 16'h2000, 16'h0000);
    model = 16'h0000;
    for (int k = 0; k < 6; k++) begin
      stepChk("R6 reverse carry small step", 6, model);
      model = rcModel(model, 16'h2000);
    end
    peek("R6 after small steps", 6, model);
  endtask

  task automatic testReload();
    cfg(9, 2'b11, 16'd40, 16'd100);
    stepChk("R7 start", 9, 16'd100);
    stepChk("R7 reloaded", 9, 16'd40);
    stepChk("R7 stays at step", 9, 16'd40);
  endtask

  task automatic testIsolation();
    peek("R8 pair4 before", 4, 16'hFFFD);
    stepChk("R8 pair3 step a", 3, 16'h0008);
    stepChk("R8 pair3 step b", 3, 16'h0018);
    peek("R8 pair4 untouched", 4, 16'hFFFD);
    peek("R8 pair9 untouched", 9, 16'd40);
    peek("R8 pair3 advanced", 3, 16'h0028);
    @(negedge clk);
    @(negedge clk);
    peek("R8 idle cycles hold", 3, 16'h0028);
  endtask

  task automatic testCollision();
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = IW'(3); cfgMode = 2'b00; cfgBase = 16'd1; cfgStart = 16'd500;
    accEn = 1'b1; accIdx = IW'(3);
    peek("R9 configuration wins", 3, 16'd500);
    stepChk("R9 then steps", 3, 16'd500);
    peek("R9 step applied later", 3, 16'd501);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = IW'(5); cfgMode = 2'b00; cfgBase = 16'd7; cfgStart = 16'd77;
    accEn = 1'b1; accIdx = IW'(3);
    peek("R10 other pair configured", 5, 16'd77);
    peek("R10 accessed pair stepped", 3, 16'd502);
  endtask

  task automatic testResetMid();
    doReset();
    peek("R1 pair3 cleared by reset", 3, 16'h0000);
    stepChk("R1 pair0 restart", 0, 16'h0000);
    stepChk("R1 pair0 step one", 0, 16'h0001);
    stepChk("R1 pair5 step zero after reset", 5, 16'h0000);
    peek("R1 pair5 held", 5, 16'h0000);
  endtask

  initial begin
    doReset();
    testReset();
    testInc();
    testDec();
    testRev();
    testReload();
    testIsolation();
    testCollision();
    testResetMid();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule